// File: doc/BRIEF.md
# SAR ADC Sampling Sequencer

This block sits on the host side of a 14-bit successive-approximation ADC that uses a convert-start and busy handshake and a 16-bit full-duplex serial port. Each time a sample is requested, the sequencer starts one conversion. In hardware-start mode it pulses `convst`. In software-start mode it instead sends a control word with the start bit set. It watches `busy` and runs one serial frame per conversion. In that frame it shifts a control word out on `sdo` and reads the converter's previous result in on `sdi`.

The frame can overlap the conversion, opening as soon as `busy` is seen high; this is the full-rate case. It can also be deferred until `busy` falls. Every timing limit is a count of system-clock cycles, rounded up from the configured clock period. These limits are the convert-start pulse width, the acquisition gap after `busy` falls and the conversion timeout for each speed grade. The serial clock comes from an integer divider. A request that arrives while a conversion is still running is held until the acquisition gap has elapsed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Synchronous reset leaves `convst` low, `sync_n` high, `sclk` high, and `result_valid` and `conv_timeout` low.
- R2: In hardware-start mode, each conversion starts with `convst` high for exactly 5 clock cycles (100 ns at 20 ns, rounded up). `convst` is never high while `sync_n` is low.
- R3: A conversion start (`convst` rising, or `sync_n` falling in software-start mode) comes no sooner than 17 cycles (330 ns) after `busy` was driven low. If a request is already waiting, `convst` rises exactly 19 clock periods after the falling edge of `busy` is applied.
- R4: A frame keeps `sync_n` low for exactly 16 rising edges of `sclk`, and `sclk` idles high. `sdo` carries the word most significant bit first. While `sync_n` is low, `sdo` changes only together with a falling edge of `sclk`.
- R5: `sdi` is sampled on rising `sclk` edges. When `sync_n` returns high, `result_valid` is high for exactly one cycle. In that cycle `result` holds the received bits 13..0 and `tag` holds bits 15..14.
- R6: In hardware-start mode with `xfer_after` low, the frame opens while `busy` is high.
- R7: In hardware-start mode with `xfer_after` high, the frame opens only after `busy` is low.
- R8: The start bit is bit 1 of the sent word. In software-start mode the word sent is `ctrl_word` with bit 1 forced to 1, and `convst` never rises. In hardware-start mode bit 1 is sent as 0.
- R9: A conversion times out when it has started but `busy` has not fallen after 175 cycles (fast grade, `slow_grade`=0) or 263 cycles (slow grade). The count runs from the `convst` rise, or from the `sync_n` rise of a software-start frame. On a timeout, `conv_timeout` pulses for one cycle, 176 or 264 cycles after that edge, and the sequencer returns to idle. The pulse never appears when `busy` falls in time.
- R10: Each `sample_req` pulse produces exactly one conversion. A request made while `busy` is high is held, not dropped, and is served after the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_req | input | 1 | One-cycle request for a sample |
| sw_start_mode | input | 1 | 1: start conversions through the serial start bit |
| xfer_after | input | 1 | 1: run the frame after busy falls (hardware-start mode) |
| slow_grade | input | 1 | Selects the 5.25 us conversion timeout instead of 3.5 us |
| ctrl_word | input | 16 | Control word sent in each frame |
| busy | input | 1 | Conversion-in-progress flag from the converter |
| sdi | input | 1 | Serial data from the converter |
| convst | output | 1 | Convert-start pulse |
| sync_n | output | 1 | Frame sync, low during a frame |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the converter |
| result_valid | output | 1 | One-cycle strobe for result and tag |
| result | output | 14 | Conversion result from the last frame |
| tag | output | 2 | Upper two bits of the last frame |
| conv_timeout | output | 1 | One-cycle pulse when busy fails to fall in time |

## Verification
The bench targets four corner cases:
- A request issued while `busy` is still high, which tests the exact cycle the next `convst` rises. A sequencer that measured the gap from the wrong edge would fire early or late, and one that dropped the request would fire not at all.
- The two grades' timeout windows, in both start modes. An off-by-one limit or a counter started from the wrong edge moves the timeout pulse by at least a cycle.
- Frame placement relative to `busy` in both transfer modes, which exposes a sequencer that opens the frame before the conversion starts.
- The software-start word, where a forgotten start bit leaves the converter idle and the whole transaction hangs.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int START_MIN_NS  = 100,
  parameter int ACQ_MIN_NS    = 330,
  parameter int CONV_FAST_NS  = 3500,
  parameter int CONV_SLOW_NS  = 5250,
  parameter int SCLK_HALF     = 2,
  parameter int FRAME_W       = 16,
  parameter int DATA_W        = 14,
  parameter int START_BIT     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_req,
  input  logic               sw_start_mode,
  input  logic               xfer_after,
  input  logic               slow_grade,
  input  logic [FRAME_W-1:0] ctrl_word,
  input  logic               busy,
  input  logic               sdi,
  output logic               convst,
  output logic               sync_n,
  output logic               sclk,
  output logic               sdo,
  output logic               result_valid,
  output logic [DATA_W-1:0]  result,
  output logic [FRAME_W-DATA_W-1:0] tag,
  output logic               conv_timeout
);
  localparam int PULSE_CYC = (START_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ACQ_CYC   = (ACQ_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TO_FAST   = (CONV_FAST_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TO_SLOW   = (CONV_SLOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TO_MAX    = (TO_SLOW > TO_FAST) ? TO_SLOW : TO_FAST;
  localparam int CW = $clog2(TO_MAX + 1);
  localparam int AW = $clog2(ACQ_CYC + 1);
  localparam int HW = $clog2(SCLK_HALF + 1);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(TO_MAX);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LIM_FAST  = CW'(TO_FAST);
  localparam logic [CW-1:0] LIM_SLOW  = CW'(TO_SLOW);
  localparam logic [AW-1:0] ACQ_TOP   = AW'(ACQ_CYC);
  localparam logic [HW-1:0] PH_END    = HW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BITS_DONE = BW'(FRAME_W);
  localparam logic [FRAME_W-1:0] START_MASK = {{(FRAME_W-1){1'b0}}, 1'b1} << START_BIT;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WRISE, S_WFALL, S_FRAME} st_t;

  st_t               st;
  logic [CW-1:0]     conv_cnt;
  logic [AW-1:0]     acq_cnt;
  logic [HW-1:0]     ph;
  logic [BW-1:0]     bitn;
  logic [FRAME_W-1:0] tx, rx;
  logic              pend, busy_q, m_sw, m_after;

  wire acq_done = (acq_cnt == ACQ_TOP);
  wire to_hit   = (conv_cnt >= (slow_grade ? LIM_SLOW : LIM_FAST));
  wire [FRAME_W-1:0] sw_word = ctrl_word | START_MASK;
  wire [FRAME_W-1:0] hw_word = ctrl_word & ~START_MASK;

  assign sdo = tx[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      convst       <= 1'b0;
      sync_n       <= 1'b1;
      sclk         <= 1'b1;
      tx           <= '0;
      rx           <= '0;
      bitn         <= '0;
      ph           <= '0;
      conv_cnt     <= '0;
      acq_cnt      <= ACQ_TOP;
      pend         <= 1'b0;
      busy_q       <= 1'b0;
      m_sw         <= 1'b0;
      m_after      <= 1'b0;
      result       <= '0;
      tag          <= '0;
      result_valid <= 1'b0;
      conv_timeout <= 1'b0;
    end else begin
      busy_q       <= busy;
      result_valid <= 1'b0;
      conv_timeout <= 1'b0;
      if (sample_req) pend <= 1'b1;
      if (busy_q && !busy) acq_cnt <= '0;
      else if (!acq_done) acq_cnt <= acq_cnt + 1'b1;
      if (conv_cnt != CNT_TOP) conv_cnt <= conv_cnt + 1'b1;

      case (st)
        S_IDLE: if (pend && acq_done) begin
          pend     <= 1'b0;
          m_sw     <= sw_start_mode;
          m_after  <= xfer_after;
          conv_cnt <= '0;
          if (sw_start_mode) begin
            sync_n <= 1'b0;
            sclk   <= 1'b1;
            ph     <= '0;
            bitn   <= '0;
            tx     <= sw_word;
            st     <= S_FRAME;
          end else begin
            convst <= 1'b1;
            st     <= S_PULSE;
          end
        end
        S_PULSE: if (conv_cnt == PULSE_END) begin
          convst <= 1'b0;
          st     <= S_WRISE;
        end
        S_WRISE: begin
          if (busy) begin
            if (!m_sw && !m_after) begin
              sync_n <= 1'b0;
              sclk   <= 1'b1;
              ph     <= '0;
              bitn   <= '0;
              tx     <= hw_word;
              st     <= S_FRAME;
            end else st <= S_WFALL;
          end else if (to_hit) begin
            conv_timeout <= 1'b1;
            acq_cnt      <= '0;
            st           <= S_IDLE;
          end
        end
        S_WFALL: begin
          if (!busy) begin
            if (!m_sw && m_after) begin
              sync_n <= 1'b0;
              sclk   <= 1'b1;
              ph     <= '0;
              bitn   <= '0;
              tx     <= hw_word;
              st     <= S_FRAME;
            end else st <= S_IDLE;
          end else if (to_hit) begin
            conv_timeout <= 1'b1;
            acq_cnt      <= '0;
            st           <= S_IDLE;
          end
        end
        S_FRAME: begin
          if (ph == PH_END) begin
            ph <= '0;
            if (sclk) begin
              if (bitn == BITS_DONE) begin
                sync_n       <= 1'b1;
                result       <= rx[DATA_W-1:0];
                tag          <= rx[FRAME_W-1:DATA_W];
                result_valid <= 1'b1;
                if (m_sw) begin
                  conv_cnt <= '0;
                  st       <= S_WRISE;
                end else if (m_after) st <= S_IDLE;
                else st <= S_WFALL;
              end else begin
                sclk <= 1'b0;
                if (bitn != '0) tx <= {tx[FRAME_W-2:0], 1'b0};
              end
            end else begin
              sclk <= 1'b1;
              rx   <= {rx[FRAME_W-2:0], sdi};
              bitn <= bitn + 1'b1;
            end
          end else ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic convst,
  input logic sync_n,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic result_valid,
  input logic conv_timeout
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) sync_n |-> sclk); // R4
  AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && $past(!sync_n) && !$fell(sclk)) |-> $stable(sdo)); // R4
  AST_NO_PULSE_IN_FRAME: assert property (@(posedge clk) disable iff (rst) !sync_n |-> !convst); // R2
  AST_START_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) $rose(convst) |-> !busy); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) result_valid |=> !result_valid); // R5
  AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (rst) result_valid |-> $rose(sync_n)); // R5
  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst) conv_timeout |=> !conv_timeout); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .convst(convst), .sync_n(sync_n), .sclk(sclk), .sdo(sdo),
  .busy(busy), .result_valid(result_valid), .conv_timeout(conv_timeout)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int ACQ = 17, PUL = 5, TOF = 175, TOS = 263;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, sample_req, sw_start_mode, xfer_after, slow_grade;
  logic [15:0] ctrl_word;
  logic busy = 1'b0, sdi = 1'b0;
  logic convst, sync_n, sclk, sdo, result_valid, conv_timeout;
  logic [13:0] result;
  logic [1:0] tag;

  adc_seq_ctrl dut (
    .clk(clk), .rst(rst), .sample_req(sample_req), .sw_start_mode(sw_start_mode),
    .xfer_after(xfer_after), .slow_grade(slow_grade), .ctrl_word(ctrl_word),
    .busy(busy), .sdi(sdi), .convst(convst), .sync_n(sync_n), .sclk(sclk),
    .sdo(sdo), .result_valid(result_valid), .result(result), .tag(tag),
    .conv_timeout(conv_timeout)
  );

  int nvec = 0, nerr = 0, cyc = 0;
  bit done = 0;
  int conv_len = 60;
  bit hang = 0;
  int trig_cd = 0, busy_left = 0, since_fall = 0;
  bit seen_fall = 0, exp_exact = 0;
  bit cv_q = 0, sy_q = 1, sk_q = 1, sdo_q = 0, rv_q = 0;
  int rises = 0, n_convst = 0, frames = 0, to_count = 0, rise_cyc = 0, ref_cyc = 0;
  logic [15:0] cap = '0, adc_word = '0;

  function automatic logic [15:0] exp_word(input logic sw, input logic [15:0] cw);
    return sw ? (cw | 16'h0002) : (cw & 16'hFFFD);
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  // Converter model, evaluated away from the active edge
  always @(negedge clk) begin
    bit trig;
    trig = 0;
    cyc++;
    if (!busy && seen_fall) since_fall++;
    if (!rst) begin
      if (convst && !cv_q) begin
        n_convst++;
        rise_cyc = cyc;
        ref_cyc = cyc;
        trig = 1;
        chk(!sw_start_mode, "R8 convst in sw mode", 1, 0);
        if (seen_fall) chk(since_fall >= ACQ, "R3 gap", since_fall, ACQ);
        if (exp_exact) begin
          chk(since_fall == ACQ + 2, "R3 exact start", since_fall, ACQ + 2);
          exp_exact = 0;
        end
      end
      if (!convst && cv_q) chk(cyc - rise_cyc == PUL, "R2 pulse width", cyc - rise_cyc, PUL);
      if (!sync_n && sy_q) begin
        rises = 0;
        sdi = adc_word[15];
        if (!sw_start_mode)
          chk(busy == !xfer_after, xfer_after ? "R7 frame after busy" : "R6 frame in busy", busy, !xfer_after);
        else if (seen_fall) chk(since_fall >= ACQ, "R3 sw gap", since_fall, ACQ);
      end
      if (!sync_n && !sy_q && sdo != sdo_q && !(!sclk && sk_q))
        chk(0, "R4 sdo moved off falling edge", sdo, sdo_q);
      if (!sync_n && sclk && !sk_q) begin
        cap = {cap[14:0], sdo};
        rises++;
      end
      if (!sync_n && !sclk && sk_q && rises > 0 && rises < 16) sdi = adc_word[15 - rises];
      if (sync_n && !sy_q) begin
        frames++;
        chk(rises == 16, "R4 sclk rises", rises, 16);
        chk(cap == exp_word(sw_start_mode, ctrl_word), "R8 sent word", cap, exp_word(sw_start_mode, ctrl_word));
        chk(result_valid == 1'b1, "R5 valid at close", result_valid, 1);
        chk(result == adc_word[13:0], "R5 result", result, adc_word[13:0]);
        chk(tag == adc_word[15:14], "R5 tag", tag, adc_word[15:14]);
        if (cap[1]) begin
          trig = 1;
          ref_cyc = cyc;
        end
      end
      if (rv_q && result_valid) chk(0, "R5 valid longer than one cycle", 1, 0);
      if (conv_timeout) begin
        to_count++;
        chk(cyc - ref_cyc == (slow_grade ? TOS : TOF) + 1, "R9 timeout cycle",
            cyc - ref_cyc, (slow_grade ? TOS : TOF) + 1);
      end
    end
    if (trig) trig_cd = 2;
    else if (trig_cd > 0) begin
      trig_cd--;
      if (trig_cd == 0) begin
        busy = 1;
        busy_left = conv_len;
      end
    end else if (busy && !hang) begin
      if (busy_left > 0) busy_left--;
      if (busy_left == 0) begin
        busy = 0;
        since_fall = 0;
        seen_fall = 1;
      end
    end
    cv_q = convst; sy_q = sync_n; sk_q = sclk; sdo_q = sdo; rv_q = result_valid;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic request;
    sample_req = 1;
    step(1);
    sample_req = 0;
  endtask

  task automatic settle(input int f0);
    while (frames <= f0) step(1);
    step(4);
    while (busy) step(1);
    step(ACQ + 6);
  endtask

  task automatic txn(input bit sw, input bit aft, input bit slow, input logic [15:0] cw,
                     input logic [15:0] aw, input int len);
    int n0, t0, f0;
    sw_start_mode = sw; xfer_after = aft; slow_grade = slow; ctrl_word = cw;
    adc_word = aw; conv_len = len;
    n0 = n_convst; t0 = to_count; f0 = frames;
    request;
    settle(f0);
    chk(n_convst - n0 == (sw ? 0 : 1), sw ? "R8 no convst" : "R10 one convst", n_convst - n0, sw ? 0 : 1);
    chk(to_count == t0, "R9 no false timeout", to_count, t0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report;
  end

  initial begin
    int n0, f0, t0;
    rst = 1; sample_req = 0; sw_start_mode = 0; xfer_after = 0; slow_grade = 0; ctrl_word = '0;
    void'($urandom(32'h5EED1234));
    step(3);
    chk(convst == 0, "R1 convst", convst, 0);
    chk(sync_n == 1, "R1 sync_n", sync_n, 1);
    chk(sclk == 1, "R1 sclk", sclk, 1);
    chk(result_valid == 0, "R1 valid", result_valid, 0);
    chk(conv_timeout == 0, "R1 timeout", conv_timeout, 0);
    rst = 0;
    step(2);

    txn(0, 0, 0, 16'h8001, 16'hA5C3, 90);   // R6
    txn(0, 1, 0, 16'h7FFF, 16'h3C5A, 40);   // R7
    txn(1, 0, 0, 16'h1230, 16'hF00F, 70);   // R8
    txn(1, 0, 1, 16'hFFFF, 16'h0001, 30);   // R8

    // R10: request while busy is high, then exact start per R3
    sw_start_mode = 0; xfer_after = 0; slow_grade = 0; ctrl_word = 16'h4444;
    adc_word = 16'h6789; conv_len = 150;
    n0 = n_convst; f0 = frames;
    request;
    while (frames <= f0) step(1);
    chk(busy == 1, "R10 busy during held request", busy, 1);
    exp_exact = 1;
    request;
    settle(f0 + 1);
    chk(n_convst - n0 == 2, "R10 held request served", n_convst - n0, 2);
    chk(exp_exact == 0, "R3 exact start seen", exp_exact, 0);

    // R9: fast-grade timeout in hardware-start mode
    hang = 1; t0 = to_count;
    sw_start_mode = 0; xfer_after = 0; slow_grade = 0;
    request;
    step(TOF + 120);
    chk(to_count == t0 + 1, "R9 fast timeout fired", to_count, t0 + 1);
    hang = 0;
    while (busy) step(1);
    step(ACQ + 6);

    // R9: slow-grade timeout in software-start mode
    hang = 1; t0 = to_count;
    sw_start_mode = 1; slow_grade = 1;
    request;
    step(TOS + 120);
    chk(to_count == t0 + 1, "R9 slow timeout fired", to_count, t0 + 1);
    hang = 0;
    while (busy) step(1);
    step(ACQ + 6);

    for (int i = 0; i < 40; i++) begin
      txn(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
          20 + int'($urandom % 130));
    end
    report;
  end
endmodule